// File: doc/BRIEF.md
# Synchronous Burst SRAM Command Front-End

This block sits behind the control pins of a synchronous burst SRAM. On every rising clock edge it samples two chip enables, two address strobes, an advance input and three kinds of write control. From these it decides whether the cycle is a deselect, the start of a burst, a step to the next burst address, or a repeat of the current address. It also decides which byte lanes are written. A small behavioural array with four byte lanes stores the data. Read data leaves through either a bypass path, which shows data in the cycle right after the command edge, or an output register, which adds one cycle. A level input selects the path at run time.

The two strobes have a fixed priority. The processor-side strobe always starts a read. Only the controller-side strobe can start a write burst, and only while the processor-side strobe is idle. A global write input overrides the per-lane strobes. An asynchronous output enable gates the read data valid flag. A burst step stays inside an aligned group of four words: the two low address bits count up modulo four and the upper bits are held.

Top module: `sburst_sram_frontend`

## Requirements
- R1: The chip counts as enabled only when `cs_hi` is 1 and `cs_lo_n` is 0. A cycle with either strobe low while the chip is not enabled gives `op` = 0 (deselect) and `wmask` = 0. It writes nothing and ends any burst.
- R2: `ads_cpu_n` low with the chip enabled gives `op` = 1 (begin) and `wmask` = 0, whatever the write controls and `ads_ctl_n` show. The cycle reads the word at `addr`.
- R3: `ads_ctl_n` low with `ads_cpu_n` high and the chip enabled gives `op` = 1. The cycle uses `addr` and reads or writes according to the write controls.
- R4: With both strobes high, a burst open and `adv_n` low, `op` = 2 (continue). The address is the previous one with bits [1:0] incremented modulo 4 and the upper bits unchanged.
- R5: With both strobes high, a burst open and `adv_n` high, `op` = 3 (suspend). The previous address is used again, for a read or a write.
- R6: With both strobes high and no burst open (after reset or after a deselect), `op` = 0 and `wmask` = 0. The memory contents stay unchanged.
- R7: In any non-deselect cycle that is not a processor-strobe begin, `gwe_n` low gives `wmask` = 4'b1111.
- R8: With `gwe_n` high, `wmask` = ~`lane_we_n` when `bwe_n` is low, and 0 when `bwe_n` is high. Bit i of `wmask` writes data bits [8i+7:8i]. A cycle with `wmask` = 0 is a read.
- R9: With `reg_mode` = 0, the data of a read sampled at edge k is on `rdata` with `rdata_en` = 1 after edge k and before edge k+1.
- R10: With `reg_mode` = 1, the data of a read sampled at edge k appears after edge k+1, and `rdata_en` is 0 between edges k and k+1 if the previous cycle was not a read.
- R11: `oe_n` high forces `rdata_en` = 0 and `rdata` = 0 at once, without waiting for a clock. `oe_n` low raises `rdata_en` only while a read result is present. A write cycle presents no result.
- R12: After a deselect edge, `rdata_en` falls after that edge in bypass mode, and after the following edge in registered mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_hi | input | 1 | Chip enable, active high |
| cs_lo_n | input | 1 | Chip enable, active low |
| ads_cpu_n | input | 1 | Processor-side address strobe, read only, highest priority |
| ads_ctl_n | input | 1 | Controller-side address strobe, may start writes |
| adv_n | input | 1 | Burst advance, active low |
| gwe_n | input | 1 | Global write, all lanes |
| bwe_n | input | 1 | Byte-write enable |
| lane_we_n | input | 4 | Per-lane write strobes, active low |
| addr | input | 6 | External word address |
| wdata | input | 32 | Write data, same cycle as command |
| reg_mode | input | 1 | 1 = registered read path, 0 = bypass |
| oe_n | input | 1 | Asynchronous output enable, active low |
| op | output | 2 | Cycle type: 0 deselect, 1 begin, 2 continue, 3 suspend |
| wmask | output | 4 | Lanes written this cycle |
| rdata | output | 32 | Read data, zero when not valid |
| rdata_en | output | 1 | Read data driven |

## Verification
The assertions assume that `reg_mode` changes only while no read result is in flight. They also assume that `oe_n` is the only input that can change between clock edges. The bench drives every synchronous input just after the falling edge, so each command is stable around the rising edge. It changes `reg_mode` only after two idle deselect cycles have drained the read pipeline. It moves `oe_n` between edges only to exercise its asynchronous effect. Expected words come from a reference array that the bench updates with the lane mask it derives from R7 and R8.

// File: rtl/sbf_pkg.sv
// Shared types for the burst SRAM front-end.
package sbf_pkg;
    // Cycle classification presented on the op port.
    typedef enum logic [1:0] {
        OP_DESEL = 2'd0,
        OP_BEGIN = 2'd1,
        OP_CONT  = 2'd2,
        OP_SUSP  = 2'd3
    } sbf_op_e;
endpackage

// File: rtl/sbf_decode.sv
// Command decoder: classifies the sampled control inputs into a cycle type
// and a per-lane write mask. Purely combinational.
// Assumes burst_live reflects whether a burst was opened and not yet ended.
module sbf_decode
    import sbf_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             cs_hi,
    input  logic             cs_lo_n,
    input  logic             ads_cpu_n,
    input  logic             ads_ctl_n,
    input  logic             adv_n,
    input  logic             gwe_n,
    input  logic             bwe_n,
    input  logic [LANES-1:0] lane_we_n,
    input  logic             burst_live,
    output sbf_op_e          op_o,
    output logic [LANES-1:0] wmask_o,
    output logic             load_o,
    output logic             kill_o,
    output logic             read_o
);
    logic             chip_on;
    logic [LANES-1:0] lane_sel;

    // Derive the chip enable and the lane mask the write controls request.
    always_comb begin
        chip_on  = cs_hi & ~cs_lo_n;
        if (!gwe_n)
            lane_sel = '1;
        else if (!bwe_n)
            lane_sel = ~lane_we_n;
        else
            lane_sel = '0;
    end

    // Apply strobe priority and burst state to pick the cycle type.
    always_comb begin
        op_o    = OP_DESEL;
        wmask_o = '0;
        load_o  = 1'b0;
        kill_o  = 1'b0;
        if (!ads_cpu_n) begin
            if (chip_on) begin
                op_o   = OP_BEGIN;
                load_o = 1'b1;
            end else begin
                kill_o = 1'b1;
            end
        end else if (!ads_ctl_n) begin
            if (chip_on) begin
                op_o    = OP_BEGIN;
                load_o  = 1'b1;
                wmask_o = lane_sel;
            end else begin
                kill_o = 1'b1;
            end
        end else if (burst_live) begin
            op_o    = adv_n ? OP_SUSP : OP_CONT;
            wmask_o = lane_sel;
        end
        read_o = (op_o != OP_DESEL) && (wmask_o == '0);
    end
endmodule

// File: rtl/sbf_burst.sv
// Burst address keeper: holds the last used address and the open-burst flag,
// and produces the address of the present cycle. A step wraps inside an
// aligned group of four words.
module sbf_burst
    import sbf_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  sbf_op_e           op_i,
    input  logic              load_i,
    input  logic              kill_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] cur_addr_o,
    output logic              live_o
);
    localparam logic [ADDR_W-1:0] WRAP_MASK = ADDR_W'(3);

    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] stepped;

    // Select the address used by this cycle.
    always_comb begin
        stepped = (base_q & ~WRAP_MASK) | ((base_q + ADDR_W'(1)) & WRAP_MASK);
        unique case (op_i)
            OP_BEGIN: cur_addr_o = addr_i;
            OP_CONT:  cur_addr_o = stepped;
            default:  cur_addr_o = base_q;
        endcase
    end

    // Remember the used address and track whether a burst is open.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            live_o <= 1'b0;
        end else begin
            if (op_i != OP_DESEL)
                base_q <= cur_addr_o;
            if (load_i)
                live_o <= 1'b1;
            else if (kill_i)
                live_o <= 1'b0;
        end
    end
endmodule

// File: rtl/sbf_array.sv
// Behavioural storage: one array per byte lane, written on the clock edge
// under the lane mask. The read address is registered so that the word of a
// read sampled at edge k is available right after that edge.
module sbf_array #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    access_i,
    input  logic [LANES-1:0]        wmask_i,
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic [LANES*LANE_W-1:0] wdata_i,
    output logic [LANES*LANE_W-1:0] rword_o
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [ADDR_W-1:0] raddr_q;

    // Capture the address of every non-deselect cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            raddr_q <= '0;
        else if (access_i)
            raddr_q <= addr_i;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];

        // Write this lane when its mask bit is set.
        always_ff @(posedge clk) begin
            if (wmask_i[g])
                cells[addr_i] <= wdata_i[g*LANE_W +: LANE_W];
        end

        assign rword_o[g*LANE_W +: LANE_W] = cells[raddr_q];
    end
endmodule

// File: rtl/sbf_outpath.sv
// Read output stage: bypass or registered data path, a valid pipeline of
// matching depth, and asynchronous gating by the output enable.
// Assumes reg_mode changes only while no read result is in flight.
module sbf_outpath #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_fire_i,
    input  logic              reg_mode_i,
    input  logic              oe_n_i,
    input  logic [DATA_W-1:0] rword_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              rdata_en_o
);
    logic              rd_q;
    logic              rd_q2;
    logic [DATA_W-1:0] dout_q;
    logic              have;

    // Track read results and hold the registered copy of the data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q   <= 1'b0;
            rd_q2  <= 1'b0;
            dout_q <= '0;
        end else begin
            rd_q   <= rd_fire_i;
            rd_q2  <= rd_q;
            dout_q <= rword_i;
        end
    end

    // Pick the path and gate with the asynchronous output enable.
    always_comb begin
        have       = reg_mode_i ? rd_q2 : rd_q;
        rdata_en_o = have & ~oe_n_i;
        if (!rdata_en_o)
            rdata_o = '0;
        else if (reg_mode_i)
            rdata_o = dout_q;
        else
            rdata_o = rword_i;
    end
endmodule

// File: rtl/sburst_sram_frontend.sv
// Top level of the burst SRAM command front-end: decoder, burst address
// keeper, lane storage and read output stage. Write data is taken in the same
// cycle as its command. Synchronous active-low reset; memory is not reset.
module sburst_sram_frontend
    import sbf_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cs_hi,
    input  logic                    cs_lo_n,
    input  logic                    ads_cpu_n,
    input  logic                    ads_ctl_n,
    input  logic                    adv_n,
    input  logic                    gwe_n,
    input  logic                    bwe_n,
    input  logic [LANES-1:0]        lane_we_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic                    reg_mode,
    input  logic                    oe_n,
    output logic [1:0]              op,
    output logic [LANES-1:0]        wmask,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    rdata_en
);
    localparam int DATA_W = LANES * LANE_W;

    sbf_op_e           op_w;
    logic              load_w;
    logic              kill_w;
    logic              read_w;
    logic              burst_live;
    logic [ADDR_W-1:0] cur_addr;
    logic [DATA_W-1:0] rword;

    sbf_decode #(.LANES(LANES)) u_dec (
        .cs_hi      (cs_hi),
        .cs_lo_n    (cs_lo_n),
        .ads_cpu_n  (ads_cpu_n),
        .ads_ctl_n  (ads_ctl_n),
        .adv_n      (adv_n),
        .gwe_n      (gwe_n),
        .bwe_n      (bwe_n),
        .lane_we_n  (lane_we_n),
        .burst_live (burst_live),
        .op_o       (op_w),
        .wmask_o    (wmask),
        .load_o     (load_w),
        .kill_o     (kill_w),
        .read_o     (read_w)
    );

    sbf_burst #(.ADDR_W(ADDR_W)) u_brst (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_i       (op_w),
        .load_i     (load_w),
        .kill_i     (kill_w),
        .addr_i     (addr),
        .cur_addr_o (cur_addr),
        .live_o     (burst_live)
    );

    sbf_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
        .clk      (clk),
        .rst_n    (rst_n),
        .access_i (op_w != OP_DESEL),
        .wmask_i  (wmask),
        .addr_i   (cur_addr),
        .wdata_i  (wdata),
        .rword_o  (rword)
    );

    sbf_outpath #(.DATA_W(DATA_W)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_fire_i  (read_w),
        .reg_mode_i (reg_mode),
        .oe_n_i     (oe_n),
        .rword_i    (rword),
        .rdata_o    (rdata),
        .rdata_en_o (rdata_en)
    );

    assign op = op_w;
endmodule

// File: rtl/sbf_checker.sv
// Protocol checker for the burst SRAM front-end, attached by bind.
module sbf_checker #(
    parameter int LANES  = 4,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_hi,
    input logic              cs_lo_n,
    input logic              ads_cpu_n,
    input logic              ads_ctl_n,
    input logic              adv_n,
    input logic              gwe_n,
    input logic              bwe_n,
    input logic              reg_mode,
    input logic              oe_n,
    input logic [1:0]        op,
    input logic [LANES-1:0]  wmask,
    input logic [DATA_W-1:0] rdata,
    input logic              rdata_en,
    input logic              live
);
    a_r1_disabled_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        ((!ads_cpu_n || !ads_ctl_n) && !(cs_hi && !cs_lo_n)) |-> (op == 2'd0 && wmask == '0));

    a_r2_cpu_strobe_reads: assert property (@(posedge clk) disable iff (!rst_n)
        (!ads_cpu_n && cs_hi && !cs_lo_n) |-> (op == 2'd1 && wmask == '0));

    a_r4_continue: assert property (@(posedge clk) disable iff (!rst_n)
        (ads_cpu_n && ads_ctl_n && live && !adv_n) |-> (op == 2'd2));

    a_r5_suspend: assert property (@(posedge clk) disable iff (!rst_n)
        (ads_cpu_n && ads_ctl_n && live && adv_n) |-> (op == 2'd3));

    a_r6_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (ads_cpu_n && ads_ctl_n && !live) |-> (op == 2'd0 && wmask == '0));

    a_r7_global_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!gwe_n && ads_cpu_n && op != 2'd0) |-> (&wmask));

    a_r8_no_byte_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (gwe_n && bwe_n) |-> (wmask == '0));

    a_r11_oe_gates: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> (!rdata_en && rdata == '0));

    a_r12_deselect_off: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 2'd0 && !reg_mode) |=> (reg_mode || !rdata_en));
endmodule

bind sburst_sram_frontend sbf_checker #(.LANES(LANES), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_hi     (cs_hi),
    .cs_lo_n   (cs_lo_n),
    .ads_cpu_n (ads_cpu_n),
    .ads_ctl_n (ads_ctl_n),
    .adv_n     (adv_n),
    .gwe_n     (gwe_n),
    .bwe_n     (bwe_n),
    .reg_mode  (reg_mode),
    .oe_n      (oe_n),
    .op        (op),
    .wmask     (wmask),
    .rdata     (rdata),
    .rdata_en  (rdata_en),
    .live      (burst_live)
);

// File: tb/sim_sburst_sram_frontend.sv
// Self-checking bench: reference array, lane-mask sweep, both read paths,
// burst stepping, deselects and output-enable gating.
module sim_sburst_sram_frontend;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_hi, cs_lo_n, ads_cpu_n, ads_ctl_n, adv_n, gwe_n, bwe_n;
    logic [3:0]  lane_we_n;
    logic [5:0]  addr;
    logic [31:0] wdata;
    logic        reg_mode, oe_n;
    logic [1:0]  op;
    logic [3:0]  wmask;
    logic [31:0] rdata;
    logic        rdata_en;

    int total = 0;
    int fails = 0;
    logic [31:0] refm [64];

    sburst_sram_frontend u0 (
        .clk(clk), .rst_n(rst_n), .cs_hi(cs_hi), .cs_lo_n(cs_lo_n),
        .ads_cpu_n(ads_cpu_n), .ads_ctl_n(ads_ctl_n), .adv_n(adv_n),
        .gwe_n(gwe_n), .bwe_n(bwe_n), .lane_we_n(lane_we_n), .addr(addr),
        .wdata(wdata), .reg_mode(reg_mode), .oe_n(oe_n), .op(op),
        .wmask(wmask), .rdata(rdata), .rdata_en(rdata_en)
    );

    always #2 clk = ~clk;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cmd(input logic ehi, input logic elo_n, input logic cpu_n,
                       input logic ctl_n, input logic av_n, input logic gw_n,
                       input logic bw_n, input logic [3:0] ln_n,
                       input logic [5:0] a, input logic [31:0] d);
        cs_hi = ehi; cs_lo_n = elo_n; ads_cpu_n = cpu_n; ads_ctl_n = ctl_n;
        adv_n = av_n; gwe_n = gw_n; bwe_n = bw_n; lane_we_n = ln_n;
        addr = a; wdata = d;
        #1;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] d,
                                          input logic [3:0] m);
        logic [31:0] r = old;
        for (int i = 0; i < 4; i++)
            if (m[i]) r[i*8 +: 8] = d[i*8 +: 8];
        return r;
    endfunction

    function automatic logic [3:0] exp_mask(input logic gw_n, input logic bw_n,
                                            input logic [3:0] ln_n);
        if (!gw_n) return 4'hF;
        if (!bw_n) return ~ln_n;
        return 4'h0;
    endfunction

    function automatic logic [5:0] nxt(input logic [5:0] a);
        return {a[5:2], a[1:0] + 2'd1};
    endfunction

    // Controller-strobe write at address a (R3, R7, R8).
    task automatic wr(input logic [5:0] a, input logic [31:0] d, input logic gw_n,
                      input logic bw_n, input logic [3:0] ln_n);
        logic [3:0] m = exp_mask(gw_n, bw_n, ln_n);
        cmd(1, 0, 1, 0, 1, gw_n, bw_n, ln_n, a, d);
        chk(gw_n ? "R8 lane mask" : "R7 global mask", 64'(wmask), 64'(m));
        chk("R3 begin on controller strobe", 64'(op), 64'd1);
        step();
        refm[a] = merge(refm[a], d, m);
    endtask

    // Processor-strobe read in bypass mode with write controls asserted (R2, R9).
    task automatic rd_flow(input logic [5:0] a, input string req);
        cmd(1, 0, 0, 0, 1, 0, 0, 4'h0, a, 32'hDEAD_BEEF);
        chk("R2 processor strobe op", 64'(op), 64'd1);
        chk("R2 processor strobe mask", 64'(wmask), 64'd0);
        step();
        chk(req, 64'(rdata_en), 64'd1);
        chk(req, 64'(rdata), 64'(refm[a]));
    endtask

    task automatic idle_desel();
        cmd(0, 0, 1, 0, 1, 1, 1, 4'hF, 6'd0, 32'd0);
        step();
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [5:0] ba;
        reg_mode = 1'b0;
        oe_n = 1'b0;
        @(negedge clk);
        cmd(1, 0, 1, 1, 0, 0, 1, 4'hF, 6'd0, 32'd0);
        step();
        step();
        chk("R6 reset no result", 64'(rdata_en), 64'd0);
        chk("R6 reset idle op", 64'(op), 64'd0);
        rst_n = 1'b1;
        cmd(1, 0, 1, 1, 0, 0, 1, 4'hF, 6'd0, 32'd0);
        chk("R6 idle after reset op", 64'(op), 64'd0);
        chk("R6 idle after reset mask", 64'(wmask), 64'd0);

        // Fill with global writes; byte-write controls set against it (R7).
        for (int i = 0; i < 64; i++) begin
            refm[i] = 32'h0;
            wr(6'(i), 32'h1000_0000 + 32'(i) * 32'h0103_0507, 0, 1, 4'hA);
        end
        // Lane-mask sweep over all 16 combinations (R8).
        for (int m = 0; m < 16; m++)
            wr(6'(m + 16), 32'hA0B0_C0D0 ^ (32'(m) * 32'h1111_1111), 1, 0, ~4'(m));
        // Byte strobes without byte-write enable: a read (R8).
        wr(6'd40, 32'hFFFF_FFFF, 1, 1, 4'h0);
        chk("R8 no enable is read", 64'(rdata), 64'(refm[40]));

        // Readback of the whole array in bypass mode (R2, R9).
        for (int i = 0; i < 64; i++)
            rd_flow(6'(i), "R9 bypass readback");

        // Bypass path: nothing shown before the command edge (R9).
        idle_desel();
        cmd(1, 0, 0, 1, 1, 1, 1, 4'hF, 6'd5, 32'd0);
        chk("R9 bypass not before edge", 64'(rdata_en), 64'd0);
        step();
        chk("R9 bypass data", 64'(rdata), 64'(refm[5]));

        // Burst stepping and suspend (R4, R5).
        ba = 6'd6;
        cmd(1, 0, 1, 0, 1, 1, 1, 4'hF, ba, 32'd0);
        step();
        chk("R3 controller read", 64'(rdata), 64'(refm[ba]));
        for (int k = 0; k < 4; k++) begin
            ba = nxt(ba);
            cmd(1, 0, 1, 1, 0, 1, 1, 4'hF, 6'd63, 32'd0);
            chk("R4 continue op", 64'(op), 64'd2);
            step();
            chk("R4 continue address", 64'(rdata), 64'(refm[ba]));
        end
        cmd(1, 0, 1, 1, 1, 1, 1, 4'hF, 6'd63, 32'd0);
        chk("R5 suspend op", 64'(op), 64'd3);
        step();
        chk("R5 suspend address", 64'(rdata), 64'(refm[ba]));
        ba = nxt(ba);
        cmd(1, 0, 1, 1, 0, 0, 1, 4'hF, 6'd63, 32'hC0DE_0001);
        chk("R7 continue write mask", 64'(wmask), 64'hF);
        step();
        chk("R11 write gives no result", 64'(rdata_en), 64'd0);
        refm[ba] = 32'hC0DE_0001;
        cmd(1, 0, 1, 1, 1, 1, 0, 4'hE, 6'd63, 32'h5555_5577);
        chk("R5 suspend write op", 64'(op), 64'd3);
        step();
        refm[ba] = merge(refm[ba], 32'h5555_5577, 4'h1);

        // Disabled strobe is a deselect and ends the burst (R1, R12, R6).
        cmd(1, 1, 1, 0, 1, 0, 1, 4'hF, ba, 32'hBAD0_0000);
        chk("R1 disabled op", 64'(op), 64'd0);
        chk("R1 disabled mask", 64'(wmask), 64'd0);
        step();
        chk("R12 bypass off after deselect", 64'(rdata_en), 64'd0);
        cmd(0, 0, 0, 1, 1, 0, 0, 4'h0, ba, 32'hBAD0_0001);
        chk("R1 low enable op", 64'(op), 64'd0);
        step();
        cmd(1, 0, 1, 1, 0, 0, 0, 4'h0, 6'd0, 32'hBAD0_0002);
        chk("R6 no burst op", 64'(op), 64'd0);
        chk("R6 no burst mask", 64'(wmask), 64'd0);
        step();
        rd_flow(ba, "R6 memory unchanged");
        rd_flow(nxt(ba), "R1 memory unchanged");

        // Output enable (R11).
        idle_desel();
        oe_n = 1'b1;
        cmd(1, 0, 0, 1, 1, 1, 1, 4'hF, 6'd3, 32'd0);
        step();
        chk("R11 oe high en", 64'(rdata_en), 64'd0);
        chk("R11 oe high data", 64'(rdata), 64'd0);
        oe_n = 1'b0;
        #1;
        chk("R11 oe low async en", 64'(rdata_en), 64'd1);
        chk("R11 oe low async data", 64'(rdata), 64'(refm[3]));
        oe_n = 1'b1;
        #1;
        chk("R11 oe high async", 64'(rdata_en), 64'd0);
        oe_n = 1'b0;

        // Registered path (R10, R12).
        idle_desel();
        idle_desel();
        reg_mode = 1'b1;
        cmd(1, 0, 0, 1, 1, 1, 1, 4'hF, 6'd10, 32'd0);
        step();
        chk("R10 no data after first edge", 64'(rdata_en), 64'd0);
        for (int i = 11; i < 20; i++) begin
            cmd(1, 0, 0, 1, 1, 1, 1, 4'hF, 6'(i), 32'd0);
            step();
            chk("R10 registered en", 64'(rdata_en), 64'd1);
            chk("R10 registered data", 64'(rdata), 64'(refm[i - 1]));
        end
        cmd(0, 0, 0, 1, 1, 1, 1, 4'hF, 6'd0, 32'd0);
        step();
        chk("R12 registered last data", 64'(rdata), 64'(refm[19]));
        idle_desel();
        chk("R12 registered off", 64'(rdata_en), 64'd0);

        summary();
        $finish;
    end
endmodule